// File: doc/BRIEF.md
# Crate Bus Master Controller

This block is the master end of a synchronous parallel bus that ties one master module in an instrument crate to up to 255 slave modules. It owns the bus: it drives the slave reset line, a trigger line that all slaves see on the same clock edge, an 8-bit slot address, a slot select, a transfer strobe, a direction line and a qualifier that says whether the 16-bit data bus carries a register address or a data word. Slaves answer the slot select and the transfer strobe on two separate active-low acknowledge lines.

After reset the controller runs a discovery pass. It puts each slot address from 1 upward on the bus, raises the slot select and waits a bounded number of clocks for the acknowledge. Slots that answer are recorded in a presence map; slot 0 is reserved and never probed. Once discovery ends, a single shared active-low interrupt line from the slaves starts a sweep that reads one data word from every recorded slot, lowest address first. A simple request port lets the local controller write a register of any slot: one transfer carries the register address, a second carries the value. Any select or transfer that is not acknowledged within the timeout is abandoned and reported with the slot address.

Top module: `crate_bus_master`

## Requirements
- R1: While rst_n is low, addr_sel, data_sel, scan_done, slave_rst_n and every bit of present_map are 0; slave_rst_n is 1 from the first clock after reset is released.
- R2: Discovery probes slot addresses 1, 2, … MAX_ADDR in ascending order; each probe holds addr_sel high for exactly one clock when addr_ack_n is low at the first sampling edge, or for exactly TIMEOUT clocks when no acknowledge arrives, followed by one clock with addr_sel low.
- R3: After discovery, scan_done is 1 and present_map bit k is 1 exactly for the slots that acknowledged their probe; bit 0 is always 0 and the map does not change afterwards.
- R4: When irq_n is low in the idle state, irq_ack pulses for one clock and every slot set in present_map is read once in ascending order; each read transfer has rd_wr=1 and addr_or_data=0, and rd_valid pulses with rd_addr and rd_data equal to the slot and the word on bus_din when data_ack_n was seen low.
- R5: An accepted write makes two transfers to wr_addr with rd_wr=0 and bus_doe=1: first addr_or_data=1 with bus_dout=wr_reg, then addr_or_data=0 with bus_dout=wr_data.
- R6: If addr_ack_n (after a select outside discovery) or data_ack_n (after data_sel) stays high for TIMEOUT clocks, err_valid pulses for one clock with err_addr equal to the slot, the transaction is dropped without further transfers, and an ongoing sweep continues at the next recorded slot.
- R7: wr_ready is 1 only in the idle state; a write request present in the same idle clock as a low irq_n is served before the sweep.
- R8: trig equals the value trig_req had one clock earlier.
- R9: data_sel is never high without addr_sel, and never stays high for more than TIMEOUT consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| slave_rst_n | output | 1 | Active-low reset driven to all slaves |
| trig | output | 1 | Synchronous trigger to all slaves |
| trig_req | input | 1 | Local trigger request |
| slot_addr | output | ADDR_W | Slot address on the bus |
| addr_sel | output | 1 | Slot select |
| addr_ack_n | input | 1 | Active-low slot select acknowledge |
| data_sel | output | 1 | Transfer strobe |
| data_ack_n | input | 1 | Active-low transfer acknowledge |
| rd_wr | output | 1 | 1 = read from slave, 0 = write to slave |
| addr_or_data | output | 1 | 1 = data bus carries a register address, 0 = data |
| bus_dout | output | DATA_W | Data bus value driven by the master |
| bus_doe | output | 1 | Master drives the data bus |
| bus_din | input | DATA_W | Data bus value driven by a slave |
| irq_n | input | 1 | Shared active-low slave service request |
| irq_ack | output | 1 | One-clock acknowledge of a service request |
| wr_req | input | 1 | Write request |
| wr_addr | input | ADDR_W | Target slot of the write |
| wr_reg | input | DATA_W | Register address of the write |
| wr_data | input | DATA_W | Value of the write |
| wr_ready | output | 1 | Controller idle, write request taken this clock |
| rd_valid | output | 1 | One-clock pulse: sweep read word available |
| rd_addr | output | ADDR_W | Slot of the read word |
| rd_data | output | DATA_W | Read word |
| err_valid | output | 1 | One-clock pulse: acknowledge timeout |
| err_addr | output | ADDR_W | Slot that timed out |
| present_map | output | MAX_ADDR+1 | Bit k set when slot k answered discovery |
| scan_done | output | 1 | Discovery finished |

## Verification
The properties take for granted that slaves acknowledge only while selected, that they drop addr_ack_n and data_ack_n as soon as addr_sel and data_sel fall, and that write request fields are steady while wr_req is high. The bench models the slaves as combinational responders keyed on slot_addr, so acknowledges follow the strobes in the same clock and fall with them, and one slot can be told to stay silent in its transfer phase to exercise the timeout. Inputs change only on the falling edge and are held until the controller shows it has taken them.

// File: rtl/crate_bus_master.sv
module crate_bus_master #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int MAX_ADDR = 255,
  parameter int TIMEOUT  = 165
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              slave_rst_n,
  output logic              trig,
  input  logic              trig_req,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              addr_sel,
  input  logic              addr_ack_n,
  output logic              data_sel,
  input  logic              data_ack_n,
  output logic              rd_wr,
  output logic              addr_or_data,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              irq_n,
  output logic              irq_ack,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [MAX_ADDR:0] present_map,
  output logic              scan_done
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(MAX_ADDR);

  typedef enum logic [2:0] {
    S_PROBE, S_PGAP, S_IDLE, S_SWEEP, S_SEL, S_XFER, S_XGAP, S_END
  } state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic              is_wr, second, sweeping;
  logic [DATA_W-1:0] reg_q, val_q;
  logic              expired;

  assign expired      = (cnt == CNT_LAST);
  assign addr_sel     = (st == S_PROBE) || (st == S_SEL) || (st == S_XFER) || (st == S_XGAP);
  assign data_sel     = (st == S_XFER);
  assign rd_wr        = !is_wr;
  assign addr_or_data = !second;
  assign bus_dout     = second ? val_q : reg_q;
  assign bus_doe      = data_sel && is_wr;
  assign wr_ready     = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_PGAP;
      slot_addr   <= '0;
      cnt         <= '0;
      is_wr       <= 1'b0;
      second      <= 1'b1;
      sweeping    <= 1'b0;
      reg_q       <= '0;
      val_q       <= '0;
      present_map <= '0;
      scan_done   <= 1'b0;
      slave_rst_n <= 1'b0;
      trig        <= 1'b0;
      irq_ack     <= 1'b0;
      rd_valid    <= 1'b0;
      rd_addr     <= '0;
      rd_data     <= '0;
      err_valid   <= 1'b0;
      err_addr    <= '0;
    end else begin
      slave_rst_n <= 1'b1;
      trig        <= trig_req;
      irq_ack     <= 1'b0;
      rd_valid    <= 1'b0;
      err_valid   <= 1'b0;
      case (st)
        S_PROBE: begin
          if (!addr_ack_n) begin
            present_map[slot_addr] <= 1'b1;
            st  <= S_PGAP;
            cnt <= '0;
          end else if (expired) begin
            st  <= S_PGAP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PGAP: begin
          if (slot_addr == LAST_SLOT) begin
            st        <= S_IDLE;
            scan_done <= 1'b1;
          end else begin
            slot_addr <= slot_addr + 1'b1;
            st        <= S_PROBE;
          end
        end
        S_IDLE: begin
          cnt <= '0;
          if (wr_req) begin
            slot_addr <= wr_addr;
            reg_q     <= wr_reg;
            val_q     <= wr_data;
            is_wr     <= 1'b1;
            second    <= 1'b0;
            sweeping  <= 1'b0;
            st        <= S_SEL;
          end else if (!irq_n) begin
            irq_ack   <= 1'b1;
            slot_addr <= ADDR_W'(1);
            is_wr     <= 1'b0;
            sweeping  <= 1'b1;
            st        <= S_SWEEP;
          end
        end
        S_SWEEP: begin
          if (present_map[slot_addr]) begin
            second <= 1'b1;
            cnt    <= '0;
            st     <= S_SEL;
          end else if (slot_addr == LAST_SLOT) begin
            sweeping <= 1'b0;
            st       <= S_IDLE;
          end else slot_addr <= slot_addr + 1'b1;
        end
        S_SEL: begin
          if (!addr_ack_n) begin
            cnt <= '0;
            st  <= S_XFER;
          end else if (expired) begin
            err_valid <= 1'b1;
            err_addr  <= slot_addr;
            st        <= S_END;
          end else cnt <= cnt + 1'b1;
        end
        S_XFER: begin
          if (!data_ack_n) begin
            if (!is_wr) begin
              rd_valid <= 1'b1;
              rd_addr  <= slot_addr;
              rd_data  <= bus_din;
            end
            st <= S_XGAP;
          end else if (expired) begin
            err_valid <= 1'b1;
            err_addr  <= slot_addr;
            st        <= S_END;
          end else cnt <= cnt + 1'b1;
        end
        S_XGAP: begin
          cnt <= '0;
          if (is_wr && !second) begin
            second <= 1'b1;
            st     <= S_XFER;
          end else st <= S_END;
        end
        default: begin
          cnt <= '0;
          if (sweeping && slot_addr != LAST_SLOT) begin
            slot_addr <= slot_addr + 1'b1;
            st        <= S_SWEEP;
          end else begin
            sweeping <= 1'b0;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module crate_bus_master_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int MAX_ADDR = 255,
  parameter int TIMEOUT  = 165
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_rst_n,
  input logic              trig,
  input logic              trig_req,
  input logic              addr_sel,
  input logic              data_sel,
  input logic              data_ack_n,
  input logic              rd_wr,
  input logic              bus_doe,
  input logic              irq_ack,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              err_valid,
  input logic [MAX_ADDR:0] present_map,
  input logic              scan_done
);
  logic [15:0] ds_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ds_run <= '0;
    else if (data_sel) ds_run <= ds_run + 1'b1;
    else ds_run <= '0;
  end

  a_r1_slave_reset_held: assert property (@(posedge clk) !rst_n |-> !slave_rst_n);
  a_r3_slot0_never: assert property (@(posedge clk) disable iff (!rst_n) !present_map[0]);
  a_r3_map_frozen: assert property (@(posedge clk) disable iff (!rst_n) scan_done |=> $stable(present_map));
  a_r4_irq_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |=> !irq_ack);
  a_r4_read_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(data_sel && !data_ack_n && rd_wr));
  a_r5_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n) bus_doe |-> (data_sel && !rd_wr));
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n) err_valid |=> !err_valid);
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n) wr_ready |-> (!addr_sel && !scan_done == 1'b0));
  a_r8_trigger_follow: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> trig == $past(trig_req));
  a_r9_ds_under_as: assert property (@(posedge clk) disable iff (!rst_n) data_sel |-> addr_sel);
  a_r9_ds_bounded: assert property (@(posedge clk) disable iff (!rst_n) data_sel |-> ds_run < 16'(TIMEOUT));
endmodule

bind crate_bus_master crate_bus_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ADDR(MAX_ADDR), .TIMEOUT(TIMEOUT)
) u_chk (.*);

// File: tb/sim_crate_bus_master.sv
`timescale 1ns/1ps
module sim_crate_bus_master;
  localparam int TO = 6;
  localparam int MA = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slave_rst_n, trig, trig_req = 1'b0;
  logic [7:0] slot_addr;
  logic addr_sel, addr_ack_n, data_sel, data_ack_n, rd_wr, addr_or_data, bus_doe;
  logic [15:0] bus_dout, bus_din;
  logic irq_n, irq_ack;
  logic wr_req = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [15:0] wr_reg = '0, wr_data = '0;
  logic wr_ready, rd_valid, err_valid, scan_done;
  logic [7:0] rd_addr, err_addr;
  logic [15:0] rd_data;
  logic [MA:0] present_map;

  always #10 clk = ~clk;

  crate_bus_master #(.MAX_ADDR(MA), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .slave_rst_n(slave_rst_n), .trig(trig), .trig_req(trig_req),
    .slot_addr(slot_addr), .addr_sel(addr_sel), .addr_ack_n(addr_ack_n),
    .data_sel(data_sel), .data_ack_n(data_ack_n), .rd_wr(rd_wr), .addr_or_data(addr_or_data),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .irq_n(irq_n), .irq_ack(irq_ack),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_reg(wr_reg), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .err_valid(err_valid),
    .err_addr(err_addr), .present_map(present_map), .scan_done(scan_done));

  // slave population model
  logic [MA:0] pres = '0;
  logic [MA:0] pending = '0;
  int mute = -1;
  always_comb begin
    addr_ack_n = !(addr_sel && pres[slot_addr]);
    data_ack_n = !(data_sel && pres[slot_addr] && int'(slot_addr) != mute);
    bus_din    = 16'hA500 | {8'h00, slot_addr};
    irq_n      = !(|pending);
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference expectations
  int exp_rd[$];
  int exp_err[$];
  int exp_wr[$];
  int as_run = 0, as_addr = 0, scan_next = 1;
  int reads_seen = 0, acks_seen = 0, prio_snap = -1;
  int cycles = 0;
  bit timed_out = 0;

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      chk(trig == trig_req, "R8 trig", trig, trig_req);
      if (data_sel) chk(addr_sel, "R9 data_sel under addr_sel", addr_sel, 1);
      if (addr_sel) begin
        as_run++;
        as_addr = slot_addr;
      end else if (as_run > 0) begin
        if (!scan_done) begin
          chk(as_addr == scan_next, "R2 probe order", as_addr, scan_next);
          chk(as_run == (pres[as_addr] ? 1 : TO), "R2 probe length", as_run, pres[as_addr] ? 1 : TO);
          scan_next++;
        end
        as_run = 0;
      end
      if (irq_ack) acks_seen++;
      if (rd_valid) begin
        reads_seen++;
        pending[rd_addr] = 1'b0;
        if (exp_rd.size() == 0) chk(0, "R4 unexpected read", rd_addr, 0);
        else begin
          int e;
          e = exp_rd.pop_front();
          chk(rd_addr == e, "R4 read slot", rd_addr, e);
          chk(rd_data == (16'hA500 | e), "R4 read word", rd_data, 16'hA500 | e);
        end
      end
      if (data_sel && rd_wr && !data_ack_n)
        chk(!addr_or_data, "R4 read qualifier", addr_or_data, 0);
      if (err_valid) begin
        if (exp_err.size() == 0) chk(0, "R6 unexpected error", err_addr, 0);
        else begin
          int e;
          e = exp_err.pop_front();
          chk(err_addr == e, "R6 error slot", err_addr, e);
        end
      end
      if (data_sel && !data_ack_n && !rd_wr) begin
        int got;
        got = {addr_or_data, bus_dout};
        chk(bus_doe, "R5 bus driven", bus_doe, 1);
        if (prio_snap >= 0) begin
          chk(reads_seen == prio_snap, "R7 write before sweep", reads_seen, prio_snap);
          prio_snap = -1;
        end
        if (exp_wr.size() == 0) chk(0, "R5 unexpected write", got, 0);
        else begin
          int e;
          e = exp_wr.pop_front();
          chk(got == e, "R5 write transfer", got, e);
        end
      end
    end
    if (cycles > 100000 && !timed_out) begin
      timed_out = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic do_write(input int a, input int r, input int d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_req = 1'b1; wr_addr = 8'(a); wr_reg = 16'(r); wr_data = 16'(d);
    @(negedge clk);
    chk(!wr_ready, "R7 busy after accept", wr_ready, 0);
    wr_req = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (exp_rd.size() || exp_err.size() || exp_wr.size() || !wr_ready || !irq_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    pres[1] = 1; pres[3] = 1; pres[5] = 1; pres[100] = 1; pres[MA] = 1;
    repeat (3) @(negedge clk);
    chk(!addr_sel && !data_sel, "R1 bus quiet in reset", {addr_sel, data_sel}, 0);
    chk(!slave_rst_n, "R1 slave reset low", slave_rst_n, 0);
    chk(present_map == '0 && !scan_done, "R1 map clear", present_map[7:0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slave_rst_n, "R1 slave reset released", slave_rst_n, 1);

    while (!scan_done) @(negedge clk);
    chk(present_map == pres, "R3 presence map", present_map[7:0], pres[7:0]);
    chk(present_map[MA] && !present_map[0], "R3 map edges", {present_map[MA], present_map[0]}, 2);
    chk(scan_next == MA + 1, "R2 all slots probed", scan_next, MA + 1);
    chk(wr_ready, "R7 ready when idle", wr_ready, 1);

    // sweep on interrupt
    exp_rd = '{1, 3, 5, 100, 255};
    pending[3] = 1; pending[MA] = 1;
    trig_req = 1'b1;
    settle();
    chk(acks_seen == 1, "R4 one irq_ack", acks_seen, 1);
    trig_req = 1'b0;

    // direct write
    exp_wr = '{32'h10012, 32'h0BEEF};
    do_write(5, 16'h0012, 16'hBEEF);
    settle();

    // write to absent slot
    exp_err = '{7};
    do_write(7, 16'h0001, 16'h1234);
    settle();

    // silent slave during sweep
    mute = 100;
    exp_rd = '{1, 3, 5, 255};
    exp_err = '{100};
    pending[1] = 1;
    settle();
    chk(acks_seen == 2, "R6 sweep continued", acks_seen, 2);
    mute = -1;

    // write and interrupt together
    @(negedge clk);
    exp_wr = '{32'h10044, 32'h05A5A};
    exp_rd = '{1, 3, 5, 100, 255};
    prio_snap = reads_seen;
    pending[5] = 1;
    wr_req = 1'b1; wr_addr = 8'd3; wr_reg = 16'h0044; wr_data = 16'h5A5A;
    @(negedge clk);
    wr_req = 1'b0;
    settle();
    chk(prio_snap == -1, "R7 write observed first", prio_snap, -1);
    chk(present_map == pres, "R3 map unchanged", present_map[7:0], pres[7:0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule